// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block sits on a simple word-addressed register bus and drives a one-time-programmable fuse array. Software loads a word index and a value into two registers, then writes a command code into the control register. A read command fetches one array word into a result register. A program command burns the value into the addressed word and also into the following word, which serves as the redundant copy. A sense command refreshes a bank of shadow cache registers from the low words of the array, so that software can read those words directly from the upper half of the register window.

The command sequencer has five states. IDLE waits for an accepted command. READ takes one cycle, captures the array word, then returns to IDLE. PGM_PRI holds the programming pulse on the primary word for the pulse-width count, then moves to PGM_RED. PGM_RED holds the pulse on the redundant word for the same count, then returns to IDLE. SENSE copies one word per cycle into the cache and returns to IDLE after the last one. Rejected commands leave the sequencer in IDLE.

Three sticky lock bits protect the part. One blocks programming, one freezes every software-writable register, and one hides the key words of the cache behind an all-ones value. A power-down flag in the control register refuses reads and programs that are written together with it. The fuse array itself is a behavioural model that starts blank at reset and can only gain set bits.

Top module: `efuse_ctl`

## Requirements
- R1: After reset the control, address, read-result, write-data and all lock registers read 0, the pulse-width register (byte 0x010, bits [7:0]) reads 0xC0, the busy flag is 0 and every cache word reads 0.
- R2: Writing command code 1 into control bits [1:0] (control at byte 0x000) fetches the array word selected by the low index bits of the address register (0x004) into the read-result register (0x008); busy is high for exactly one cycle.
- R3: Writing command code 2 ORs the write-data register (0x00C) into array word N and into word N+1 modulo the array size; a set fuse bit never returns to 0.
- R4: A program keeps busy high for 2 x max(P,1) cycles, where P is the pulse-width value latched when the command is accepted (P cycles per alias).
- R5: Writing command code 3 copies array words 0 to CACHE_WORDS-1 into cache word i at byte 0x100 + 4i, one word per cycle, busy for CACHE_WORDS cycles; bus writes to the cache have no effect.
- R6: Control bit 26 is the power-down flag and reads back as written; a read or program command written with bit 26 set is refused (busy stays 0, read result and array unchanged), while a sense command still runs.
- R7: Writing 1 to bit 0 of byte 0x014 sets a sticky program lock; every later program command is refused and the array is unchanged.
- R8: Writing 1 to bit 0 of byte 0x018 sets a sticky write lock; every later bus write, including commands, is ignored.
- R9: Writing 1 to bit 0 of byte 0x01C sets a sticky key lock; afterwards the five cache words KEY_FIRST to KEY_FIRST+4 read 0xFFFFFFFF while the other cache words read normally.
- R10: Control bit 16 reads as busy; any write to the control register while busy is ignored, both its command and its bit 26.
- R11: Command code 0 starts nothing; busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | BUS_AW | Byte address of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The checker watches on every cycle that commands written with the power-down flag or under the program lock never raise busy, that the three lock bits never clear, that a write-locked register file keeps its values through any write, that the first key word reads all ones under the key lock, and that control writes during busy leave the power-down flag alone. The OR-only behaviour of the array, the alias pairing of programs, the exact busy lengths for each command and pulse width, and the cache contents after a sense are shown only by the bench, which programs every array word with a computed pattern and reads each back through read and sense commands.

// File: rtl/efuse_pkg.sv
package efuse_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_PROG  = 2'd2,
        CMD_SENSE = 2'd3
    } fuse_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_PGM_PRI,
        ST_PGM_RED,
        ST_SENSE
    } seq_state_e;

    localparam int CTRL_PDN_BIT  = 26;
    localparam int CTRL_BUSY_BIT = 16;

    // word offsets inside the register window (byte offset / 4)
    localparam int OFF_CTRL   = 0;
    localparam int OFF_ADDR   = 1;
    localparam int OFF_RDATA  = 2;
    localparam int OFF_WDATA  = 3;
    localparam int OFF_PULSE  = 4;
    localparam int OFF_PGMDIS = 5;
    localparam int OFF_WLOCK  = 6;
    localparam int OFF_KEYLCK = 7;
    localparam int OFF_CACHE  = 64;

endpackage

// File: rtl/efuse_array.sv
module efuse_array #(
    parameter int WORDS = 64,
    parameter int DW    = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] idx,
    input  logic          burn_stb,
    input  logic [DW-1:0] burn_data,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem [WORDS];

    // a burn can only add set bits to the selected word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) mem[w] <= '0;
        end else if (burn_stb) begin
            mem[idx] <= mem[idx] | burn_data;
        end
    end

    assign rd_data = mem[idx];

endmodule

// File: rtl/efuse_seq.sv
module efuse_seq
    import efuse_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 32,
    parameter int CACHE_WORDS = 16,
    parameter int PW_W        = 8,
    localparam int CW         = (CACHE_WORDS > 1) ? $clog2(CACHE_WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  fuse_cmd_e       cmd,
    input  logic [AW-1:0]   start_idx,
    input  logic [DW-1:0]   start_data,
    input  logic [PW_W-1:0] pulse_w,
    output logic            busy,
    output logic [AW-1:0]   arr_idx,
    output logic            burn_stb,
    output logic [DW-1:0]   burn_data,
    output logic            rd_stb,
    output logic            cache_we,
    output logic [CW-1:0]   cache_idx
);

    seq_state_e      state, state_nx;
    logic [PW_W-1:0] cnt, op_pw, pw_eff;
    logic [AW-1:0]   op_idx;
    logic [DW-1:0]   op_data;
    logic [CW-1:0]   sidx;

    assign pw_eff = (pulse_w == '0) ? PW_W'(1) : pulse_w;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    unique case (cmd)
                        CMD_READ:  state_nx = ST_READ;
                        CMD_PROG:  state_nx = ST_PGM_PRI;
                        CMD_SENSE: state_nx = ST_SENSE;
                        CMD_IDLE:  state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_READ:    state_nx = ST_IDLE;
            ST_PGM_PRI: if (cnt == '0) state_nx = ST_PGM_RED;
            ST_PGM_RED: if (cnt == '0) state_nx = ST_IDLE;
            ST_SENSE:   if (sidx == CW'(CACHE_WORDS - 1)) state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // operand latches and pulse / sweep counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            op_pw   <= '0;
            op_idx  <= '0;
            op_data <= '0;
            sidx    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    op_idx  <= start_idx;
                    op_data <= start_data;
                    op_pw   <= pw_eff;
                    cnt     <= pw_eff - PW_W'(1);
                    sidx    <= '0;
                end
                ST_PGM_PRI: cnt <= (cnt == '0) ? op_pw - PW_W'(1) : cnt - PW_W'(1);
                ST_PGM_RED: if (cnt != '0) cnt <= cnt - PW_W'(1);
                ST_SENSE:   sidx <= sidx + CW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        burn_stb  = ((state == ST_PGM_PRI) || (state == ST_PGM_RED)) && (cnt == '0);
        burn_data = op_data;
        rd_stb    = (state == ST_READ);
        cache_we  = (state == ST_SENSE);
        cache_idx = sidx;
        unique case (state)
            ST_SENSE:   arr_idx = AW'(sidx);
            ST_PGM_RED: arr_idx = op_idx + AW'(1);
            default:    arr_idx = op_idx;
        endcase
    end

endmodule

// File: rtl/efuse_ctl.sv
module efuse_ctl
    import efuse_pkg::*;
#(
    parameter int ARRAY_WORDS  = 64,
    parameter int CACHE_WORDS  = 16,
    parameter int KEY_FIRST    = 8,
    parameter int KEY_WORDS    = 5,
    parameter int BUS_AW       = 10,
    parameter int PW_W         = 8,
    parameter logic [PW_W-1:0] PW_RESET = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);

    localparam int AW  = $clog2(ARRAY_WORDS);
    localparam int CW  = (CACHE_WORDS > 1) ? $clog2(CACHE_WORDS) : 1;
    localparam int WAW = BUS_AW - 2;

    logic [WAW-1:0] word;
    logic           aligned, wr_ok, ctrl_wr, start, cmd_ok, busy;
    fuse_cmd_e      cmd;
    logic           pdn_q, pgm_dis_q, wlock_q, keylock_q;
    logic [31:0]    addr_q, rdata_q, wdata_q;
    logic [PW_W-1:0] pw_q;
    logic [31:0]    cache_q [CACHE_WORDS];
    logic [31:0]    arr_rd, burn_data;
    logic [AW-1:0]  arr_idx;
    logic           burn_stb, rd_stb, cache_we;
    logic [CW-1:0]  cache_idx;

    assign word    = bus_addr[BUS_AW-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_ok   = bus_we && aligned && !wlock_q;
    assign ctrl_wr = wr_ok && (word == WAW'(OFF_CTRL)) && !busy;
    assign cmd     = fuse_cmd_e'(bus_wdata[1:0]);

    always_comb begin
        unique case (cmd)
            CMD_SENSE: cmd_ok = 1'b1;
            CMD_READ:  cmd_ok = !bus_wdata[CTRL_PDN_BIT];
            CMD_PROG:  cmd_ok = !bus_wdata[CTRL_PDN_BIT] && !pgm_dis_q;
            CMD_IDLE:  cmd_ok = 1'b0;
        endcase
    end
    assign start = ctrl_wr && cmd_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pdn_q     <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            pw_q      <= PW_RESET;
            pgm_dis_q <= 1'b0;
            wlock_q   <= 1'b0;
            keylock_q <= 1'b0;
        end else begin
            if (ctrl_wr) pdn_q <= bus_wdata[CTRL_PDN_BIT];
            if (wr_ok) begin
                if (word == WAW'(OFF_ADDR))   addr_q  <= bus_wdata;
                if (word == WAW'(OFF_WDATA))  wdata_q <= bus_wdata;
                if (word == WAW'(OFF_PULSE))  pw_q    <= bus_wdata[PW_W-1:0];
                if (word == WAW'(OFF_PGMDIS) && bus_wdata[0]) pgm_dis_q <= 1'b1;
                if (word == WAW'(OFF_WLOCK)  && bus_wdata[0]) wlock_q   <= 1'b1;
                if (word == WAW'(OFF_KEYLCK) && bus_wdata[0]) keylock_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            for (int i = 0; i < CACHE_WORDS; i++) cache_q[i] <= '0;
        end else begin
            if (rd_stb) rdata_q <= arr_rd;
            if (cache_we) cache_q[cache_idx] <= arr_rd;
        end
    end

    efuse_seq #(
        .AW(AW), .DW(32), .CACHE_WORDS(CACHE_WORDS), .PW_W(PW_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
        .start_idx(addr_q[AW-1:0]), .start_data(wdata_q), .pulse_w(pw_q),
        .busy(busy), .arr_idx(arr_idx), .burn_stb(burn_stb),
        .burn_data(burn_data), .rd_stb(rd_stb), .cache_we(cache_we),
        .cache_idx(cache_idx)
    );

    efuse_array #(.WORDS(ARRAY_WORDS), .DW(32)) u_array (
        .clk(clk), .rst_n(rst_n), .idx(arr_idx), .burn_stb(burn_stb),
        .burn_data(burn_data), .rd_data(arr_rd)
    );

    // read mux; key words are masked once the key lock is set
    always_comb begin
        logic [WAW-1:0] coff;
        bus_rdata = '0;
        coff      = word - WAW'(OFF_CACHE);
        if (aligned) begin
            if (int'(word) >= OFF_CACHE) begin
                if (int'(coff) < CACHE_WORDS) begin
                    if (keylock_q && int'(coff) >= KEY_FIRST && int'(coff) < KEY_FIRST + KEY_WORDS)
                        bus_rdata = '1;
                    else
                        bus_rdata = cache_q[coff[CW-1:0]];
                end
            end else begin
                case (int'(word))
                    OFF_CTRL: begin
                        bus_rdata[CTRL_PDN_BIT]  = pdn_q;
                        bus_rdata[CTRL_BUSY_BIT] = busy;
                    end
                    OFF_ADDR:   bus_rdata = addr_q;
                    OFF_RDATA:  bus_rdata = rdata_q;
                    OFF_WDATA:  bus_rdata = wdata_q;
                    OFF_PULSE:  bus_rdata = 32'(pw_q);
                    OFF_PGMDIS: bus_rdata = {31'd0, pgm_dis_q};
                    OFF_WLOCK:  bus_rdata = {31'd0, wlock_q};
                    OFF_KEYLCK: bus_rdata = {31'd0, keylock_q};
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/efuse_ctl_chk.sv
module efuse_ctl_chk #(
    parameter int BUS_AW    = 10,
    parameter int PW_W      = 8,
    parameter int KEY_FIRST = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              busy,
    input logic              pdn_q,
    input logic              pgm_dis_q,
    input logic              wlock_q,
    input logic              keylock_q,
    input logic [31:0]       addr_q,
    input logic [31:0]       wdata_q,
    input logic [PW_W-1:0]   pw_q
);

    localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(0);
    localparam logic [BUS_AW-1:0] A_KEY0 = BUS_AW'(256 + 4 * KEY_FIRST);

    logic ctrl_w;
    assign ctrl_w = bus_we && (bus_addr == A_CTRL) && !wlock_q;

    p_pdn_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w && !busy && bus_wdata[26] && (bus_wdata[1:0] == 2'd1 || bus_wdata[1:0] == 2'd2) |=> !busy);

    p_pgm_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w && !busy && pgm_dis_q && bus_wdata[1:0] == 2'd2 |=> !busy);

    p_pgm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_dis_q |=> pgm_dis_q);

    p_wlock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wlock_q |=> wlock_q);

    p_wlock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wlock_q && bus_we |=> $stable(addr_q) && $stable(wdata_q) && $stable(pw_q) && $stable(pdn_q));

    p_key_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        keylock_q |=> keylock_q);

    p_key_hidden_r9: assert property (@(posedge clk) disable iff (!rst_n)
        keylock_q && bus_addr == A_KEY0 |-> bus_rdata == 32'hFFFF_FFFF);

    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy && ctrl_w |=> $stable(pdn_q));

    p_idle_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_w && !busy && bus_wdata[1:0] == 2'd0 |=> !busy);

endmodule

bind efuse_ctl efuse_ctl_chk #(.BUS_AW(BUS_AW), .PW_W(PW_W), .KEY_FIRST(KEY_FIRST)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .pdn_q(pdn_q), .pgm_dis_q(pgm_dis_q), .wlock_q(wlock_q),
    .keylock_q(keylock_q), .addr_q(addr_q), .wdata_q(wdata_q), .pw_q(pw_q)
);

// File: tb/efuse_ctl_test.sv
module efuse_ctl_test;

    localparam int NW = 64;
    localparam int NC = 16;
    localparam int KF = 8;
    localparam logic [9:0] A_CTRL = 10'h000, A_ADDR = 10'h004, A_RDAT = 10'h008,
                           A_WDAT = 10'h00C, A_PULSE = 10'h010, A_PDIS = 10'h014,
                           A_WLCK = 10'h018, A_KLCK = 10'h01C, A_CACHE = 10'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_mem [NW];
    logic [31:0] v, last_rd;
    int n;

    always #4 clk = ~clk;

    efuse_ctl uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cnt);
        logic [31:0] s;
        cnt = 0;
        for (int k = 0; k < 2000; k++) begin
            rd(A_CTRL, s);
            if (!s[16]) break;
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic prog(input int idx, input logic [31:0] d, output int cnt);
        wr(A_ADDR, 32'(idx));
        wr(A_WDAT, d);
        wr(A_CTRL, 32'd2);
        wait_idle(cnt);
    endtask

    task automatic fread(input int idx, output logic [31:0] d);
        int c;
        wr(A_ADDR, 32'(idx));
        wr(A_CTRL, 32'd1);
        wait_idle(c);
        rd(A_RDAT, d);
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'(i) * 32'h0103_0507) ^ (32'h1 << (i % 32));
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) exp_mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CTRL, v);  check("R1 ctrl", v, 32'd0);
        rd(A_ADDR, v);  check("R1 addr", v, 32'd0);
        rd(A_RDAT, v);  check("R1 rdata", v, 32'd0);
        rd(A_PULSE, v); check("R1 pulse", v, 32'h0000_00C0);
        rd(A_PDIS, v);  check("R1 pgm lock", v, 32'd0);
        rd(A_WLCK, v);  check("R1 write lock", v, 32'd0);
        rd(A_KLCK, v);  check("R1 key lock", v, 32'd0);
        rd(A_CACHE, v); check("R1 cache", v, 32'd0);

        // R3 sweep: program every word, redundant alias gets the same bits
        wr(A_PULSE, 32'd1);
        for (int i = 0; i < NW; i++) begin
            prog(i, pat(i), n);
            exp_mem[i] |= pat(i);
            exp_mem[(i + 1) % NW] |= pat(i);
        end
        // R2 read back every word
        for (int i = 0; i < NW; i++) begin
            fread(i, v);
            check("R2/R3 array word", v, exp_mem[i]);
        end
        // R3 OR-only: add low half to word 40, alias 41
        prog(40, 32'h0000_FFFF, n);
        exp_mem[40] |= 32'h0000_FFFF; exp_mem[41] |= 32'h0000_FFFF;
        fread(40, v); check("R3 OR primary", v, exp_mem[40]);
        fread(41, v); check("R3 OR redundant", v, exp_mem[41]);
        // R3 wrap: last word aliases word 0
        prog(NW - 1, 32'h8000_0000, n);
        exp_mem[NW - 1] |= 32'h8000_0000; exp_mem[0] |= 32'h8000_0000;
        fread(0, v); check("R3 wrap alias", v, exp_mem[0]);

        // R4 timing for several pulse widths, R2 read busy length
        wr(A_PULSE, 32'd3); prog(60, 32'd0, n); check("R4 busy pw3", 32'(n), 32'd6);
        wr(A_PULSE, 32'd0); prog(60, 32'd0, n); check("R4 busy pw0", 32'(n), 32'd2);
        wr(A_PULSE, 32'd5); prog(60, 32'd0, n); check("R4 busy pw5", 32'(n), 32'd10);
        wr(A_ADDR, 32'd7); wr(A_CTRL, 32'd1); wait_idle(n);
        check("R2 read busy", 32'(n), 32'd1);

        // R5 sense
        wr(A_CTRL, 32'd3); wait_idle(n);
        check("R5 sense busy", 32'(n), 32'(NC));
        for (int i = 0; i < NC; i++) begin
            rd(A_CACHE + 10'(4 * i), v);
            check("R5 cache word", v, exp_mem[i]);
        end
        wr(A_CACHE, 32'hDEAD_BEEF);
        rd(A_CACHE, v); check("R5 cache read-only", v, exp_mem[0]);

        // R10 control write during busy is ignored
        fread(3, last_rd);
        wr(A_PULSE, 32'd3);
        wr(A_ADDR, 32'd50); wr(A_WDAT, 32'h00F0_0F00); wr(A_CTRL, 32'd2);
        wr(A_CTRL, 32'h0400_0001);
        wait_idle(n);
        check("R10 remaining busy", 32'(n), 32'd4);
        exp_mem[50] |= 32'h00F0_0F00; exp_mem[51] |= 32'h00F0_0F00;
        rd(A_CTRL, v); check("R10 pdn untouched", v, 32'd0);
        rd(A_RDAT, v); check("R10 read ignored", v, last_rd);
        fread(51, v);  check("R10 program kept", v, exp_mem[51]);
        last_rd = v;

        // R11 idle command
        wr(A_CTRL, 32'd0); rd(A_CTRL, v); check("R11 idle no busy", v, 32'd0);

        // R6 power-down
        wr(A_ADDR, 32'd20); wr(A_WDAT, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h0400_0002);
        rd(A_CTRL, v); check("R6 program refused", v, 32'h0400_0000);
        wr(A_CTRL, 32'h0400_0001);
        rd(A_CTRL, v); check("R6 read refused", v, 32'h0400_0000);
        rd(A_RDAT, v); check("R6 rdata kept", v, last_rd);
        wr(A_CTRL, 32'h0400_0003);
        rd(A_CTRL, v); check("R6 sense runs", v, 32'h0401_0000);
        wait_idle(n);
        fread(20, v); check("R6 array unchanged", v, exp_mem[20]);

        // R9 key lock
        wr(A_KLCK, 32'd1);
        for (int i = KF; i < KF + 5; i++) begin
            rd(A_CACHE + 10'(4 * i), v); check("R9 key hidden", v, 32'hFFFF_FFFF);
        end
        rd(A_CACHE + 10'(4 * (KF - 1)), v); check("R9 below key", v, exp_mem[KF - 1]);
        rd(A_CACHE + 10'(4 * (KF + 5)), v); check("R9 above key", v, exp_mem[KF + 5]);
        wr(A_KLCK, 32'd0);
        rd(A_CACHE + 10'(4 * KF), v); check("R9 sticky", v, 32'hFFFF_FFFF);

        // R7 program lock
        wr(A_PDIS, 32'd1);
        prog(30, 32'hFFFF_FFFF, n); check("R7 no busy", 32'(n), 32'd0);
        fread(30, v); check("R7 array unchanged", v, exp_mem[30]);
        fread(31, v); check("R7 alias unchanged", v, exp_mem[31]);
        wr(A_PDIS, 32'd0);
        rd(A_PDIS, v); check("R7 sticky", v, 32'd1);

        // R8 write lock
        wr(A_ADDR, 32'd9);
        wr(A_WLCK, 32'd1);
        wr(A_ADDR, 32'd44);  rd(A_ADDR, v);  check("R8 addr frozen", v, 32'd9);
        wr(A_PULSE, 32'h55); rd(A_PULSE, v); check("R8 pulse frozen", v, 32'd3);
        wr(A_CTRL, 32'd3);   rd(A_CTRL, v);  check("R8 command ignored", v, 32'd0);
        wr(A_WLCK, 32'd0);   rd(A_WLCK, v);  check("R8 sticky", v, 32'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule